// File: doc/BRIEF.md
# Clause 45 Management Interface Master

This block lets a host processor reach the management registers of one or more external PHY devices over a two-wire MDC/MDIO link, using only IEEE Clause 45 framing. The host sees four 32-bit registers. None of them has a "go" bit of its own. Instead, a frame is started as a side effect of a host write. Writing the address register sends an address frame. Writing the data register sends a write frame. Writing the command register with bit 15 set sends a read frame. The port and device fields held in the command register select the target of every frame.

The host moves step by step. It polls the busy flag until it clears, writes the next register, and then polls again. A read ends with the 16-bit result placed in the data register. If the PHY fails to answer during the turnaround, the error flag is raised instead. The speed of the management clock comes from a half-period count. That count is loaded through the same register that reports busy and error.

Top module: `mdio_c45_master`

## Requirements
- R1: After reset the status register (offset 3) reads busy=0 (bit 0), error=0 (bit 1) and the reset half-period (2) in bits [15:7]. MDC is low and MDIO is not driven (mdio_oe=0). Whenever no frame is running, MDC stays low and MDIO stays released.
- R2: The command register (offset 0) holds the device number in bits [4:0] and the port address in bits [9:5], and reads them back. A command write with bit 15 clear starts no frame.
- R3: A write to the address register (offset 1) sends one 64-bit frame, MSB first: 32 ones, start 00, opcode 00, port[4:0], device[4:0], turnaround 10, then the low 16 bits written. The address register reads those 16 bits back.
- R4: A write to the data register (offset 2) sends the same frame layout with opcode 01, carrying the low 16 bits of the written value. The data register reads back the full 32-bit value written.
- R5: A command write with bit 15 set sends a read frame with opcode 11 to the port and device in that same write. MDIO is released (mdio_oe=0) from the first turnaround bit (frame bit 46) to the end. The 16 bits sampled in frame bits 48..63, MSB first, go into data register bits [15:0], with bits [31:16] reading zero.
- R6: Status bit 0 (busy) is set from the clock edge that accepts a launching write until the MDC falling edge that ends bit 63.
- R7: In a read frame, if the PHY does not hold the second turnaround bit (frame bit 47) low, status bit 1 (error) is set at the end of the frame and the data register keeps its old value. The error bit clears when the next frame starts.
- R8: While busy is set, host writes to any of the four registers are ignored. They change no register and start no frame.
- R9: A status write with bit 6 set loads bits [15:7] as the MDC half-period in clock cycles, with 0 taken as 1. A status write with bit 6 clear changes nothing. The MDC period equals twice the loaded value.
- R10: The master changes MDIO only at an MDC falling edge, or at frame start while MDC is low. It samples MDIO at the MDC rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_waddr | input | 2 | Register offset for the write |
| host_wdata | input | 32 | Write data |
| host_raddr | input | 2 | Register offset for the read |
| host_rdata | output | 32 | Read data for host_raddr (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable, high while the master drives |
| mdio_i | input | 1 | MDIO value seen on the pin |

## Verification
The hardest situation to reach is a host write that lands in the middle of a running frame. Such a write must be dropped completely, leaving no trace in any register and starting no second frame. The bench issues writes to all four offsets right after an address frame starts. It then reads every register back and confirms that the scoreboard saw exactly one frame. A bench PHY model follows the MDC rising edges, so it can drive a bad second turnaround bit on demand. This exercises the error path, and the next launch then clears the error. The half-period is also forced to its clamped minimum of one, where the capture path has only a single cycle per MDC phase.

// File: rtl/mdio_c45_pkg.sv
package mdio_c45_pkg;

    // Frame geometry (bit indices counted from the first preamble bit)
    localparam int FRAME_BITS = 64;
    localparam int PRE_BITS   = 32;
    localparam int TA1_BIT    = 46;   // first turnaround bit
    localparam int TA2_BIT    = 47;   // second turnaround bit, PHY drives 0
    localparam int DATA_BIT   = 48;   // first data bit
    localparam int LAST_BIT   = FRAME_BITS - 1;

    // Clause 45 opcodes
    typedef enum logic [1:0] {
        OP_ADDR  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b11
    } c45_op_e;

    // Host register offsets
    localparam logic [1:0] OFS_CMD  = 2'd0;
    localparam logic [1:0] OFS_ADDR = 2'd1;
    localparam logic [1:0] OFS_DATA = 2'd2;
    localparam logic [1:0] OFS_STAT = 2'd3;

    // Bit positions inside host registers
    localparam int CMD_READ_BIT = 15;
    localparam int STAT_BUSY    = 0;
    localparam int STAT_ERR     = 1;
    localparam int STAT_CFG_EN  = 6;
    localparam int STAT_DIV_LSB = 7;

endpackage

// File: rtl/mdio_c45_clkgen.sv
// Management clock generator: runs only while a frame is active and
// flags the cycle in which MDC rises or falls.
module mdio_c45_clkgen #(
    parameter int DIV_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_cnt,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);
    localparam int CW = DIV_W + 1;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } ck_s;

    ck_s ck_d, ck_q;
    logic tick;

    always_comb begin
        ck_d = ck_q;
        tick = run && ((CW'(ck_q.cnt) + CW'(1)) >= CW'(half_cnt));
        rise_stb = tick && !ck_q.mdc;
        fall_stb = tick &&  ck_q.mdc;
        if (!run) begin
            ck_d = '0;
        end else if (tick) begin
            ck_d.cnt = '0;
            ck_d.mdc = !ck_q.mdc;
        end else begin
            ck_d.cnt = ck_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ck_q <= '0;
        else        ck_q <= ck_d;
    end

    assign mdc = ck_q.mdc;

endmodule

// File: rtl/mdio_c45_engine.sv
// Frame serializer: shifts one 64-bit Clause 45 frame out on MDIO,
// releases the line for the read turnaround and captures read data.
module mdio_c45_engine
    import mdio_c45_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [1:0]  op,
    input  logic [4:0]  prtad,
    input  logic [4:0]  devad,
    input  logic [15:0] payload,
    input  logic        rise_stb,
    input  logic        fall_stb,
    input  logic        mdio_i,
    output logic        busy,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        done,
    output logic        done_read,
    output logic        rd_fail,
    output logic [15:0] rd_cap
);
    typedef struct packed {
        logic                  busy;
        logic                  is_read;
        logic [5:0]            idx;
        logic [FRAME_BITS-1:0] shreg;
        logic [15:0]           cap;
        logic                  ta_bad;
        logic                  done;
    } eng_s;

    eng_s en_d, en_q;

    always_comb begin
        en_d      = en_q;
        en_d.done = 1'b0;
        if (start && !en_q.busy) begin
            en_d.busy    = 1'b1;
            en_d.is_read = (op == OP_READ);
            en_d.idx     = '0;
            en_d.shreg   = {{PRE_BITS{1'b1}}, 2'b00, op, prtad, devad, 2'b10, payload};
            en_d.cap     = '0;
            en_d.ta_bad  = 1'b0;
        end else if (en_q.busy) begin
            // sample on the MDC rising edge
            if (rise_stb && en_q.is_read) begin
                if (en_q.idx == 6'(TA2_BIT))
                    en_d.ta_bad = mdio_i;
                if (en_q.idx >= 6'(DATA_BIT))
                    en_d.cap = {en_q.cap[14:0], mdio_i};
            end
            // advance on the MDC falling edge
            if (fall_stb) begin
                if (en_q.idx == 6'(LAST_BIT)) begin
                    en_d.busy = 1'b0;
                    en_d.done = 1'b1;
                end else begin
                    en_d.idx   = en_q.idx + 1'b1;
                    en_d.shreg = {en_q.shreg[FRAME_BITS-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign busy      = en_q.busy;
    assign mdio_o    = en_q.busy ? en_q.shreg[FRAME_BITS-1] : 1'b1;
    assign mdio_oe   = en_q.busy && !(en_q.is_read && (en_q.idx >= 6'(TA1_BIT)));
    assign done      = en_q.done;
    assign done_read = en_q.done && en_q.is_read;
    assign rd_fail   = en_q.ta_bad;
    assign rd_cap    = en_q.cap;

endmodule

// File: rtl/mdio_c45_regs.sv
// Host register file: decodes writes into frame launches, holds the
// target fields, the data word, the error flag and the MDC half-period.
module mdio_c45_regs
    import mdio_c45_pkg::*;
#(
    parameter int              DIV_W     = 9,
    parameter logic [DIV_W-1:0] DIV_RESET = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [31:0]      wr_data,
    input  logic [1:0]       rd_addr,
    output logic [31:0]      rd_data,
    input  logic             busy,
    input  logic             done_read,
    input  logic             rd_fail,
    input  logic [15:0]      rd_cap,
    output logic             start,
    output logic [1:0]       op,
    output logic [4:0]       prtad,
    output logic [4:0]       devad,
    output logic [15:0]      payload,
    output logic [DIV_W-1:0] half_cnt,
    output logic             err
);
    typedef struct packed {
        logic [4:0]       prt;
        logic [4:0]       dev;
        logic [15:0]      addr;
        logic [31:0]      data;
        logic [DIV_W-1:0] div;
        logic             err;
    } reg_s;

    reg_s rg_d, rg_q;
    logic             accept;
    logic [DIV_W-1:0] div_field;
    logic [31:0]      stat_word;

    always_comb begin
        rg_d      = rg_q;
        accept    = wr_en && !busy;
        start     = 1'b0;
        op        = OP_ADDR;
        prtad     = rg_q.prt;
        devad     = rg_q.dev;
        payload   = rg_q.addr;
        div_field = wr_data[STAT_DIV_LSB +: DIV_W];

        if (accept) begin
            case (wr_addr)
                OFS_CMD: begin
                    rg_d.dev = wr_data[4:0];
                    rg_d.prt = wr_data[9:5];
                    if (wr_data[CMD_READ_BIT]) begin
                        start = 1'b1;
                        op    = OP_READ;
                        devad = wr_data[4:0];
                        prtad = wr_data[9:5];
                    end
                end
                OFS_ADDR: begin
                    rg_d.addr = wr_data[15:0];
                    start     = 1'b1;
                    op        = OP_ADDR;
                    payload   = wr_data[15:0];
                end
                OFS_DATA: begin
                    rg_d.data = wr_data;
                    start     = 1'b1;
                    op        = OP_WRITE;
                    payload   = wr_data[15:0];
                end
                default: begin
                    if (wr_data[STAT_CFG_EN])
                        rg_d.div = (div_field == '0) ? DIV_W'(1) : div_field;
                end
            endcase
        end

        if (start)
            rg_d.err = 1'b0;

        // completion of a read frame
        if (done_read) begin
            rg_d.err = rd_fail;
            if (!rd_fail)
                rg_d.data = {16'h0000, rd_cap};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q     <= '0;
            rg_q.div <= DIV_RESET;
        end else begin
            rg_q <= rg_d;
        end
    end

    always_comb begin
        stat_word                            = '0;
        stat_word[STAT_BUSY]                 = busy;
        stat_word[STAT_ERR]                  = rg_q.err;
        stat_word[STAT_DIV_LSB +: DIV_W]     = rg_q.div;
        case (rd_addr)
            OFS_CMD:  rd_data = {22'h0, rg_q.prt, rg_q.dev};
            OFS_ADDR: rd_data = {16'h0, rg_q.addr};
            OFS_DATA: rd_data = rg_q.data;
            default:  rd_data = stat_word;
        endcase
    end

    assign half_cnt = rg_q.div;
    assign err      = rg_q.err;

endmodule

// File: rtl/mdio_c45_master.sv
module mdio_c45_master
    import mdio_c45_pkg::*;
#(
    parameter int               DIV_W     = 9,
    parameter logic [DIV_W-1:0] DIV_RESET = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic [1:0]  host_waddr,
    input  logic [31:0] host_wdata,
    input  logic [1:0]  host_raddr,
    output logic [31:0] host_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic             busy;
    logic             start;
    logic             done;
    logic             done_read;
    logic             rd_fail;
    logic [15:0]      rd_cap;
    logic [1:0]       op;
    logic [4:0]       prtad;
    logic [4:0]       devad;
    logic [15:0]      payload;
    logic [DIV_W-1:0] half_cnt;
    logic             err;
    logic             rise_stb;
    logic             fall_stb;

    mdio_c45_regs #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (host_wr),
        .wr_addr   (host_waddr),
        .wr_data   (host_wdata),
        .rd_addr   (host_raddr),
        .rd_data   (host_rdata),
        .busy      (busy),
        .done_read (done_read),
        .rd_fail   (rd_fail),
        .rd_cap    (rd_cap),
        .start     (start),
        .op        (op),
        .prtad     (prtad),
        .devad     (devad),
        .payload   (payload),
        .half_cnt  (half_cnt),
        .err       (err)
    );

    mdio_c45_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .half_cnt (half_cnt),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_c45_engine u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op        (op),
        .prtad     (prtad),
        .devad     (devad),
        .payload   (payload),
        .rise_stb  (rise_stb),
        .fall_stb  (fall_stb),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .done      (done),
        .done_read (done_read),
        .rd_fail   (rd_fail),
        .rd_cap    (rd_cap)
    );

endmodule

// File: rtl/mdio_c45_checker.sv
module mdio_c45_checker #(
    parameter int DIV_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             start,
    input logic             done,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_oe,
    input logic [DIV_W-1:0] half_cnt,
    input logic             err
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe)); // R1

    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R8

    AST_DIV_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(half_cnt)); // R8

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy); // R6

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R6

    AST_ERR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(done)); // R7

    AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdio_o)); // R10

endmodule

bind mdio_c45_master mdio_c45_checker #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/mdio_c45_master_bench.sv
module mdio_c45_master_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [1:0]  host_waddr = '0;
    logic [31:0] host_wdata = '0;
    logic [1:0]  host_raddr = '0;
    logic [31:0] host_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    mdio_c45_master u_mdio_c45_master (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_waddr(host_waddr),
        .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit test_done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [63:0] bits;
        logic [63:0] oe;
        string       req;
    } frame_t;

    frame_t exp_q[$];

    function automatic frame_t mk(input logic [1:0] op, input logic [4:0] prt,
                                  input logic [4:0] dev, input logic [15:0] pay,
                                  input string req);
        frame_t f;
        f.bits = {32'hFFFF_FFFF, 2'b00, op, prt, dev, 2'b10, pay};
        f.oe   = (op == 2'b11) ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
        f.req  = req;
        return f;
    endfunction

    // PHY model state
    logic [15:0] phy_data = '0;
    logic        phy_ta2  = 1'b0;

    int          mon_idx = 0;
    logic [63:0] got_o, got_oe;
    logic        rise_val = 1'b0;
    bit          hold_bad = 0;

    // monitor and PHY responder, both keyed on MDC rising edges
    always @(posedge mdc) begin
        int nxt;
        frame_t e;
        got_o[63-mon_idx]  = mdio_o;
        got_oe[63-mon_idx] = mdio_oe;
        rise_val = mdio_o;
        nxt = mon_idx + 1;
        if (nxt == 47)                  mdio_i = phy_ta2;
        else if (nxt >= 48 && nxt < 64) mdio_i = phy_data[63-nxt];
        else                            mdio_i = 1'b1;
        if (nxt == 64) begin
            mon_idx = 0;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8", "unexpected frame", got_o, 64'h0);
            end else begin
                e = exp_q.pop_front();
                chk(got_oe == e.oe, e.req, "mdio_oe pattern", got_oe, e.oe);
                chk((got_o & e.oe) == (e.bits & e.oe), e.req, "frame bits",
                    got_o & e.oe, e.bits & e.oe);
                chk(!hold_bad, "R10", "mdio_o moved while mdc high",
                    64'(hold_bad), 64'h0);
            end
            hold_bad = 0;
        end else begin
            mon_idx = nxt;
        end
    end

    always @(negedge clk) begin
        if (mdc && (mdio_o !== rise_val)) hold_bad = 1;
    end

    // ---------------- host tasks ----------------
    task automatic hwr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_waddr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hrd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        host_raddr = a;
        #1;
        v = host_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            hrd(2'd3, s);
            if (!s[0]) break;
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!test_done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
        end
    end

    // ---------------- test sequence ----------------
    initial begin
        logic [31:0] v;
        int t1, t2;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        hrd(2'd3, v);
        chk(v == 32'h0000_0100, "R1", "status after reset", v, 32'h100);
        chk(!mdc && !mdio_oe, "R1", "pins idle", {mdc, mdio_oe}, 0);

        // R2 command fields, no frame without bit 15
        hwr(2'd0, 32'h0000_0145);
        hrd(2'd0, v);
        chk(v == 32'h0000_0145, "R2", "command readback", v, 32'h145);
        hrd(2'd3, v);
        chk(v[0] == 1'b0, "R2", "no frame from plain command write", v[0], 0);

        // R9 divider load with and without enable bit
        hwr(2'd3, (32'd3 << 7) | 32'h40);
        hrd(2'd3, v);
        chk(v[15:7] == 9'd3, "R9", "half-period loaded", v[15:7], 3);
        hwr(2'd3, (32'd5 << 7));
        hrd(2'd3, v);
        chk(v[15:7] == 9'd3, "R9", "no load without bit 6", v[15:7], 3);

        // R3 address frame, R6 busy, R9 MDC period
        exp_q.push_back(mk(2'b00, 5'h0A, 5'h05, 16'h1234, "R3"));
        hwr(2'd1, 32'hDEAD_1234);
        hrd(2'd3, v);
        chk(v[0] == 1'b1, "R6", "busy after launch", v[0], 1);
        @(posedge mdc); t1 = cyc;
        @(posedge mdc); t2 = cyc;
        chk(t2 - t1 == 6, "R9", "MDC period half=3", t2 - t1, 6);
        wait_idle();
        hrd(2'd1, v);
        chk(v == 32'h0000_1234, "R3", "address readback", v, 32'h1234);

        // R4 write frame
        exp_q.push_back(mk(2'b01, 5'h0A, 5'h05, 16'h5A5A, "R4"));
        hwr(2'd2, 32'hABCD_5A5A);
        wait_idle();
        hrd(2'd2, v);
        chk(v == 32'hABCD_5A5A, "R4", "data readback", v, 32'hABCD5A5A);

        // R5 read frame
        phy_data = 16'hC3A5; phy_ta2 = 1'b0;
        exp_q.push_back(mk(2'b11, 5'h0A, 5'h05, 16'h0, "R5"));
        hwr(2'd0, 32'h0000_8145);
        wait_idle();
        hrd(2'd2, v);
        chk(v == 32'h0000_C3A5, "R5", "read data", v, 32'hC3A5);
        hrd(2'd3, v);
        chk(v[1] == 1'b0, "R7", "no error on good read", v[1], 0);

        // R5 second pattern, other port/device
        phy_data = 16'h0F81;
        exp_q.push_back(mk(2'b11, 5'h1F, 5'h1E, 16'h0, "R5"));
        hwr(2'd0, 32'h0000_83FE);
        wait_idle();
        hrd(2'd2, v);
        chk(v == 32'h0000_0F81, "R5", "read data 2", v, 32'h0F81);

        // R7 missing turnaround
        phy_data = 16'hFFFF; phy_ta2 = 1'b1;
        exp_q.push_back(mk(2'b11, 5'h1F, 5'h1E, 16'h0, "R7"));
        hwr(2'd0, 32'h0000_83FE);
        wait_idle();
        hrd(2'd3, v);
        chk(v[1] == 1'b1, "R7", "error set", v[1], 1);
        hrd(2'd2, v);
        chk(v == 32'h0000_0F81, "R7", "data kept on error", v, 32'h0F81);
        phy_ta2 = 1'b0;

        // R7 clear on next launch, R8 ignored writes while busy
        exp_q.push_back(mk(2'b00, 5'h1F, 5'h1E, 16'h4242, "R8"));
        hwr(2'd1, 32'h0000_4242);
        hrd(2'd3, v);
        chk(v[1] == 1'b0, "R7", "error cleared at launch", v[1], 0);
        hwr(2'd0, 32'h0000_8021);
        hwr(2'd2, 32'h7777_7777);
        hwr(2'd1, 32'h0000_9999);
        hwr(2'd3, (32'd1 << 7) | 32'h40);
        wait_idle();
        repeat (100) @(negedge clk);
        hrd(2'd0, v);
        chk(v == 32'h0000_03FE, "R8", "command unchanged", v, 32'h3FE);
        hrd(2'd1, v);
        chk(v == 32'h0000_4242, "R8", "address unchanged", v, 32'h4242);
        hrd(2'd2, v);
        chk(v == 32'h0000_0F81, "R8", "data unchanged", v, 32'h0F81);
        hrd(2'd3, v);
        chk(v[15:7] == 9'd3, "R8", "divider unchanged", v[15:7], 3);
        chk(exp_q.size() == 0 && mon_idx == 0, "R8", "no extra frame",
            exp_q.size() + mon_idx, 0);

        // R9 zero clamps to one; fastest MDC with a read
        hwr(2'd3, 32'h0000_0040);
        hrd(2'd3, v);
        chk(v[15:7] == 9'd1, "R9", "zero taken as one", v[15:7], 1);
        phy_data = 16'h8001;
        exp_q.push_back(mk(2'b11, 5'h1F, 5'h1E, 16'h0, "R5"));
        hwr(2'd0, 32'h0000_83FE);
        @(posedge mdc); t1 = cyc;
        @(posedge mdc); t2 = cyc;
        chk(t2 - t1 == 2, "R9", "MDC period half=1", t2 - t1, 2);
        wait_idle();
        hrd(2'd2, v);
        chk(v == 32'h0000_8001, "R5", "read data at half=1", v, 32'h8001);

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R3", "all frames seen", exp_q.size(), 0);
        chk(!mdc && !mdio_oe, "R1", "pins idle at end", {mdc, mdio_oe}, 0);

        test_done = 1;
        summary();
    end

endmodule